// File: doc/BRIEF.md
# Sector Capture and Playback Buffer

This block decouples a slow floppy disk controller from a host CPU. Instead of taking an interrupt per byte, the CPU lets the block collect a whole 256-byte sector into a local RAM. Each data-ready strobe from the controller stores the byte the controller presents at the address held by an 8-bit device counter, and the counter then advances. When the last location has been filled, a sticky interrupt flag is raised. The CPU later drains the sector through a data register at whatever pace suits it.

The block also works in the other direction. The CPU preloads the RAM through the same data register and selects playback. Each strobe from the controller then places the next stored byte on the device output. The interrupt rises after the final byte has been handed out. A strobe that arrives while the interrupt is still pending is discarded and marked in an overrun bit. The CPU clears the interrupt and the overrun bit, and rewinds both address counters, with a single control write.

The register port uses a one-bit index. Index 0 is control on write and status on read. Index 1 is the data register. Read data appears on `host_rdata` one clock after the read access.

Top module: `sector_stage`

## Requirements
- R1: After reset, `irq` is 0, `dev_rdata` is 0, and a status read (index 0) returns 0.
- R2: Each rising edge of `dev_strobe` that is accepted advances the device counter by exactly one, however long the strobe stays high. In capture mode the byte on `dev_wdata` is stored at the counter's address, starting at address 0.
- R3: `irq` stays 0 while fewer than 256 bytes have been accepted, and becomes 1 once the byte at address 255 has been handled.
- R4: `irq` stays 1 until the host writes index 0 with bit 1 set. That write sets `irq` and the overrun bit to 0 and resets both the device counter and the host pointer to address 0.
- R5: Each host read of index 1 returns the byte at the host pointer one cycle later and advances the pointer by one, so successive reads return addresses 0, 1, 2 and onward in order.
- R6: A strobe that arrives while `irq` is 1 is dropped. It does not change the RAM or the device counter, and it sets the overrun bit (status bit 2).
- R7: With direction bit 1 (playback), each accepted strobe drives `dev_rdata` with the byte at the device counter's address, in address order from 0, and the counter advances. `irq` rises after address 255 has been delivered.
- R8: Each host write to index 1 stores `host_wdata` at the host pointer and advances the pointer by one.
- R9: A write to index 0 loads control bit 0 as the direction (0 capture, 1 playback). A status read returns bit 0 direction, bit 1 `irq` and bit 2 overrun, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_strobe | input | 1 | Asynchronous data-ready strobe from the disk controller |
| dev_wdata | input | 8 | Byte offered by the controller in capture mode |
| dev_rdata | output | 8 | Byte handed to the controller in playback mode |
| host_sel | input | 1 | Host register access in this cycle |
| host_wr | input | 1 | 1 for a write access, 0 for a read access |
| host_addr | input | 1 | Register index: 0 control/status, 1 data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid one cycle after the read access |
| irq | output | 1 | Sticky sector-complete interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit address (256 bytes), 8-bit data and a two-flop synchronizer. With these values a full counter wrap at address 255 can be reached in a few thousand cycles. The bench therefore runs complete sectors in both directions, an overrun on a pending interrupt, the rewind after a clear, and one strobe held high for many cycles.

// File: rtl/sector_stage_pkg.sv
package sector_stage_pkg;

  typedef enum logic {
    DIR_CAPTURE  = 1'b0,
    DIR_PLAYBACK = 1'b1
  } xfer_dir_e;

  localparam logic REG_CTRL = 1'b0;
  localparam logic REG_DATA = 1'b1;

  localparam int CTL_DIR_BIT = 0;
  localparam int CTL_CLR_BIT = 1;
  localparam int STS_DIR_BIT = 0;
  localparam int STS_IRQ_BIT = 1;
  localparam int STS_OVR_BIT = 2;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/sector_ram.sv
module sector_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic              b_re,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
    end else if (a_re) begin
      a_rdata <= mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_rdata <= '0;
    end else if (b_re) begin
      b_rdata <= mem[b_addr];
    end
  end

endmodule

// File: rtl/dev_engine.sv
module dev_engine
  import sector_stage_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              clear_i,
  input  xfer_dir_e         dir_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ram_we,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              irq_o,
  output logic              ovr_o
);

  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [ADDR_W-1:0] ptr_q;
  logic              irq_q;
  logic              ovr_q;
  logic              accept;

  // A clear in the same cycle as a strobe wins; the strobe is ignored.
  assign accept    = rise_i & ~irq_q & ~clear_i;
  assign ram_we    = accept & (dir_i == DIR_CAPTURE);
  assign ram_re    = accept & (dir_i == DIR_PLAYBACK);
  assign ram_addr  = ptr_q;
  assign ram_wdata = wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (clear_i) begin
      ptr_q <= '0;
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (rise_i) begin
      if (irq_q) begin
        ovr_q <= 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
        if (ptr_q == LAST) irq_q <= 1'b1;
      end
    end
  end

  assign ptr_o = ptr_q;
  assign irq_o = irq_q;
  assign ovr_o = ovr_q;

endmodule

// File: rtl/host_port.sv
module host_port
  import sector_stage_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_i,
  input  logic              ovr_i,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output xfer_dir_e         dir_o,
  output logic              clear_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              ctrl_wr;
  logic              ctrl_rd;
  logic              data_wr;
  logic              data_rd;
  logic [ADDR_W-1:0] ptr_q;
  xfer_dir_e         dir_q;
  logic [DATA_W-1:0] status_q;
  logic              data_sel_q;

  assign ctrl_wr = sel_i &  wr_i & (addr_i == REG_CTRL);
  assign ctrl_rd = sel_i & ~wr_i & (addr_i == REG_CTRL);
  assign data_wr = sel_i &  wr_i & (addr_i == REG_DATA);
  assign data_rd = sel_i & ~wr_i & (addr_i == REG_DATA);
  assign clear_o = ctrl_wr & wdata_i[CTL_CLR_BIT];

  assign ram_we    = data_wr;
  assign ram_re    = data_rd;
  assign ram_addr  = ptr_q;
  assign ram_wdata = wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_CAPTURE;
    end else if (ctrl_wr) begin
      dir_q <= xfer_dir_e'(wdata_i[CTL_DIR_BIT]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (clear_o) begin
      ptr_q <= '0;
    end else if (data_wr || data_rd) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= '0;
      data_sel_q <= 1'b0;
    end else if (ctrl_rd) begin
      status_q              <= '0;
      status_q[STS_DIR_BIT] <= dir_q;
      status_q[STS_IRQ_BIT] <= irq_i;
      status_q[STS_OVR_BIT] <= ovr_i;
      data_sel_q            <= 1'b0;
    end else if (data_rd) begin
      data_sel_q <= 1'b1;
    end
  end

  assign rdata_o = data_sel_q ? ram_rdata : status_q;
  assign dir_o   = dir_q;

endmodule

// File: rtl/sector_stage.sv
module sector_stage
  import sector_stage_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_strobe,
  input  logic [DATA_W-1:0] dev_wdata,
  output logic [DATA_W-1:0] dev_rdata,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq
);

  logic              strobe_rise;
  logic              clear;
  xfer_dir_e         dir;
  logic              overrun;
  logic [ADDR_W-1:0] dev_ptr;

  logic              a_we, a_re, b_we, b_re;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [DATA_W-1:0] a_wdata, b_wdata, b_rdata;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (dev_strobe),
    .rise     (strobe_rise)
  );

  dev_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dev (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (strobe_rise),
    .clear_i   (clear),
    .dir_i     (dir),
    .wdata_i   (dev_wdata),
    .ram_we    (a_we),
    .ram_re    (a_re),
    .ram_addr  (a_addr),
    .ram_wdata (a_wdata),
    .ptr_o     (dev_ptr),
    .irq_o     (irq),
    .ovr_o     (overrun)
  );

  host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
    .clk       (clk),
    .rst       (rst),
    .sel_i     (host_sel),
    .wr_i      (host_wr),
    .addr_i    (host_addr),
    .wdata_i   (host_wdata),
    .irq_i     (irq),
    .ovr_i     (overrun),
    .ram_rdata (b_rdata),
    .ram_we    (b_we),
    .ram_re    (b_re),
    .ram_addr  (b_addr),
    .ram_wdata (b_wdata),
    .dir_o     (dir),
    .clear_o   (clear),
    .rdata_o   (host_rdata)
  );

  sector_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .a_we    (a_we),
    .a_re    (a_re),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_rdata (dev_rdata),
    .b_we    (b_we),
    .b_re    (b_re),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .b_rdata (b_rdata)
  );

endmodule

// File: rtl/sector_stage_chk.sv
module sector_stage_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_sel,
  input logic              host_wr,
  input logic              host_addr,
  input logic              clr_bit,
  input logic              irq,
  input logic              overrun,
  input logic              strobe_rise,
  input logic [ADDR_W-1:0] dev_ptr
);

  logic host_clear;
  assign host_clear = host_sel & host_wr & ~host_addr & clr_bit;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_rise |=> !strobe_rise);

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_rise && !irq && !host_clear) |=> dev_ptr == $past(dev_ptr) + 1'b1);

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_rise && !host_clear) |=> $stable(dev_ptr));

  // R3
  irq_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(dev_ptr) == '1 && dev_ptr == '0));

  // R4
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !host_clear) |=> irq);

  // R4
  clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
    host_clear |=> (!irq && !overrun && dev_ptr == '0));

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_rise && irq && !host_clear) |=> (overrun && $stable(dev_ptr)));

endmodule

bind sector_stage sector_stage_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_sel    (host_sel),
  .host_wr     (host_wr),
  .host_addr   (host_addr),
  .clr_bit     (host_wdata[1]),
  .irq         (irq),
  .overrun     (overrun),
  .strobe_rise (strobe_rise),
  .dev_ptr     (dev_ptr)
);

// File: tb/test_sector_stage.sv
module test_sector_stage;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dev_strobe = 1'b0;
  logic [7:0] dev_wdata = '0;
  logic [7:0] dev_rdata;
  logic       host_sel = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_addr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] cap_m  [256];
  logic [7:0] play_m [256];

  always #2.5 clk = ~clk;

  sector_stage i_sector_stage (
    .clk        (clk),
    .rst        (rst),
    .dev_strobe (dev_strobe),
    .dev_wdata  (dev_wdata),
    .dev_rdata  (dev_rdata),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq        (irq)
  );

  function automatic logic [7:0] status_exp(input logic dir, input logic irq_e, input logic ovr);
    return {5'b0, ovr, irq_e, dir};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    @(negedge clk);
    host_sel = 1'b0;
    d = host_rdata;
  endtask

  task automatic dev_pulse(input logic [7:0] d, input int hold);
    @(negedge clk);
    dev_wdata = d; dev_strobe = 1'b1;
    repeat (hold) @(negedge clk);
    dev_strobe = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5EC7));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 dev_rdata", dev_rdata, 0);
    host_read(1'b0, rd);
    chk("R1 status", rd, 0);

    // R2 R3 capture a full sector; first strobe held long
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'h00 : (i == 255) ? 8'hFF : 8'($urandom);
      cap_m[i] = b;
      dev_pulse(b, (i == 0) ? 20 : 1 + int'($urandom % 3));
      if (i == 254) chk("R3 irq before last byte", irq, 0);
    end
    chk("R3 irq after last byte", irq, 1);
    host_read(1'b0, rd);
    chk("R9 status pending", rd, status_exp(0, 1, 0));

    // R6 strobe during pending interrupt
    dev_pulse(8'hA5, 2);
    host_read(1'b0, rd);
    chk("R6 overrun status", rd, status_exp(0, 1, 1));
    chk("R4 irq sticky", irq, 1);

    // R5 R2 R6 read back the sector in order
    for (int i = 0; i < 256; i++) begin
      host_read(1'b1, rd);
      chk($sformatf("R5 byte %0d", i), rd, cap_m[i]);
    end

    // R4 clear
    host_write(1'b0, 8'h02);
    chk("R4 irq cleared", irq, 0);
    host_read(1'b0, rd);
    chk("R4 status cleared", rd, status_exp(0, 0, 0));

    // R4 counters rewound: new bytes land at 0..2, host reads from 0
    for (int i = 0; i < 3; i++) begin
      cap_m[i] = 8'($urandom);
      dev_pulse(cap_m[i], 1);
    end
    chk("R3 irq after partial", irq, 0);
    for (int i = 0; i < 4; i++) begin
      host_read(1'b1, rd);
      chk($sformatf("R4 rewound byte %0d", i), rd, cap_m[i]);
    end

    // R9 playback selection plus clear
    host_write(1'b0, 8'h03);
    host_read(1'b0, rd);
    chk("R9 status playback", rd, status_exp(1, 0, 0));

    // R8 preload
    for (int i = 0; i < 256; i++) begin
      play_m[i] = (i == 0) ? 8'hFF : (i == 255) ? 8'h00 : 8'($urandom);
      host_write(1'b1, play_m[i]);
    end
    host_write(1'b0, 8'h03);
    for (int i = 0; i < 4; i++) begin
      host_read(1'b1, rd);
      chk($sformatf("R8 preload byte %0d", i), rd, play_m[i]);
    end

    // R7 playback
    for (int i = 0; i < 256; i++) begin
      dev_pulse(8'h5A, 1 + int'($urandom % 4));
      chk($sformatf("R7 played byte %0d", i), dev_rdata, play_m[i]);
      if (i == 254) chk("R7 irq before last", irq, 0);
    end
    chk("R7 irq after last", irq, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule